// File: doc/BRIEF.md
# Reverse Playback Buffer Address Generator

This block produces the two addresses used to run a circular audio sample buffer in reverse. Each time the sample strobe fires, the write pointer moves up by one and the read pointer moves down by one. Both pointers wrap inside a loop whose length is set at run time, so newly captured samples are stored in forward order and played back from the same memory in reverse.

The loop length does not jump to a new request. Each sample it moves a fixed, bounded step toward the requested target length, which keeps the size of the loop changing smoothly. A neighbouring block that blends samples across the loop seam can overwrite the read pointer in the same sample period through a load request. The sample memory, the codec link and the mixing arithmetic belong to other blocks.

Top module: `rpb_addr_gen`

## Requirements
- R1: On a strobe, the write address becomes the old write address plus one, unless R2 applies.
- R2: On a strobe, if the old write address plus one (computed without truncation) is greater than or equal to the current length as it stood before this strobe, the write address becomes 0.
- R3: On a strobe without a load request, a nonzero read address decreases by one.
- R4: On a strobe without a load request, a read address of 0 reloads to the current length before this strobe minus one.
- R5: A load request together with a strobe sets the read address to the supplied load address, taking priority over R3 and R4.
- R6: On a strobe, a current length below the target increases by 2.
- R7: On a strobe, a current length above the target decreases by 2, and a length equal to the target holds. The comparison uses the length before the step, so two even values never overshoot.
- R8: After reset the write address is 0x0000, the read address is 0xFD00 and the current length is 0x0600.
- R9: Without a strobe, all three outputs hold, and the target and load inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb_i | input | 1 | One-cycle sample strobe |
| tgt_len_i | input | 16 | Requested loop length |
| rd_load_i | input | 1 | Read pointer load request, sampled with the strobe |
| rd_load_addr_i | input | 16 | Value loaded into the read pointer |
| wr_addr_o | output | 16 | Current write address |
| rd_addr_o | output | 16 | Current read address |
| cur_len_o | output | 16 | Current loop length |

## Verification
Two functions that can meet in one strobe are the read-pointer reload at zero and the length step, and likewise the write-pointer wrap against a length that is shrinking. The bench provokes both by loading the read pointer to 0 while the length is still slewing and by lowering the target well below the write address, so the wrap and the slew land in the same sample. The result is judged against a model that always takes the length from before the step, so a design that uses the new length for the wrap or the reload is caught.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

    localparam int ADDR_W = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [ADDR_W:0]   addr_ext_t;

endpackage

// File: rtl/rpb_wr_ptr.sv
module rpb_wr_ptr
    import rpb_pkg::*;
#(
    parameter addr_t RST_VAL = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stb,
    input  addr_t len_q,
    output addr_t wr_q
);

    typedef struct packed {
        addr_t wr;
    } wr_state_t;

    wr_state_t st_d, st_q;
    addr_ext_t inc_ext;

    always_comb begin
        st_d    = st_q;
        inc_ext = {1'b0, st_q.wr} + addr_ext_t'(1);
        if (stb) begin
            if (inc_ext >= {1'b0, len_q}) begin
                st_d.wr = '0;
            end else begin
                st_d.wr = inc_ext[ADDR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wr <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_q = st_q.wr;

    // R1 / R2: a strobe either advances by one or lands on zero
    a_r1_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (wr_q == '0) || (wr_q == addr_t'($past(wr_q) + addr_t'(1))));

    // R2: wrap happens when the advanced value reaches the old length
    a_r2_wr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && ({1'b0, wr_q} + addr_ext_t'(1) >= {1'b0, len_q})) |=> (wr_q == '0));

    // R9: no strobe, no movement
    a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(wr_q));

endmodule

// File: rtl/rpb_rd_ptr.sv
module rpb_rd_ptr
    import rpb_pkg::*;
#(
    parameter addr_t RST_VAL = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stb,
    input  logic  load,
    input  addr_t load_val,
    input  addr_t len_q,
    output addr_t rd_q
);

    typedef struct packed {
        addr_t rd;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb) begin
            if (load) begin
                st_d.rd = load_val;
            end else if (st_q.rd == '0) begin
                st_d.rd = len_q - addr_t'(1);
            end else begin
                st_d.rd = st_q.rd - addr_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rd <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_q = st_q.rd;

    // R3: plain decrement away from zero
    a_r3_rd_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !load && rd_q != '0) |=> (rd_q == addr_t'($past(rd_q) - addr_t'(1))));

    // R4: reload from the length seen before the strobe
    a_r4_rd_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !load && rd_q == '0) |=> (rd_q == addr_t'($past(len_q) - addr_t'(1))));

    // R5: load wins
    a_r5_rd_load: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && load) |=> (rd_q == $past(load_val)));

    // R9: no strobe, no movement
    a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(rd_q));

endmodule

// File: rtl/rpb_len_slew.sv
module rpb_len_slew
    import rpb_pkg::*;
#(
    parameter addr_t RST_VAL = 16'h0600,
    parameter addr_t STEP    = 16'd2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stb,
    input  addr_t tgt,
    output addr_t len_q
);

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

    typedef struct packed {
        addr_t len;
    } len_state_t;

    len_state_t st_d, st_q;
    dir_e       dir;

    always_comb begin
        if (st_q.len < tgt) begin
            dir = DIR_UP;
        end else if (st_q.len > tgt) begin
            dir = DIR_DOWN;
        end else begin
            dir = DIR_HOLD;
        end
    end

    always_comb begin
        st_d = st_q;
        if (stb) begin
            unique case (dir)
                DIR_UP:   st_d.len = st_q.len + STEP;
                DIR_DOWN: st_d.len = st_q.len - STEP;
                default:  st_d.len = st_q.len;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.len <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_q = st_q.len;

    // R6: grow by one step when below target
    a_r6_len_up: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && len_q < tgt) |=> (len_q == addr_t'($past(len_q) + STEP)));

    // R7: shrink by one step when above target
    a_r7_len_down: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && len_q > tgt) |=> (len_q == addr_t'($past(len_q) - STEP)));

    // R7: equal holds
    a_r7_len_eq: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && len_q == tgt) |=> $stable(len_q));

    // R9: no strobe, no movement
    a_r9_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(len_q));

endmodule

// File: rtl/rpb_addr_gen.sv
module rpb_addr_gen
    import rpb_pkg::*;
#(
    parameter addr_t RST_WR  = 16'h0000,
    parameter addr_t RST_RD  = 16'hFD00,
    parameter addr_t RST_LEN = 16'h0600,
    parameter addr_t LEN_STEP = 16'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb_i,
    input  logic [ADDR_W-1:0] tgt_len_i,
    input  logic              rd_load_i,
    input  logic [ADDR_W-1:0] rd_load_addr_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [ADDR_W-1:0] cur_len_o
);

    addr_t len_q;
    addr_t wr_q;
    addr_t rd_q;

    rpb_len_slew #(
        .RST_VAL (RST_LEN),
        .STEP    (LEN_STEP)
    ) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (smp_stb_i),
        .tgt   (tgt_len_i),
        .len_q (len_q)
    );

    rpb_wr_ptr #(
        .RST_VAL (RST_WR)
    ) u_wr (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (smp_stb_i),
        .len_q (len_q),
        .wr_q  (wr_q)
    );

    rpb_rd_ptr #(
        .RST_VAL (RST_RD)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (smp_stb_i),
        .load     (rd_load_i),
        .load_val (rd_load_addr_i),
        .len_q    (len_q),
        .rd_q     (rd_q)
    );

    assign wr_addr_o = wr_q;
    assign rd_addr_o = rd_q;
    assign cur_len_o = len_q;

endmodule

// File: tb/rpb_addr_gen_tb.sv
module rpb_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stb = 1'b0;
    logic [15:0] tgt = 16'h0600;
    logic        ld = 1'b0;
    logic [15:0] ld_val = 16'h0000;
    logic [15:0] wr_o, rd_o, len_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_wr, m_rd, m_len;

    always #2.5 clk = ~clk;

    rpb_addr_gen u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .smp_stb_i      (stb),
        .tgt_len_i      (tgt),
        .rd_load_i      (ld),
        .rd_load_addr_i (ld_val),
        .wr_addr_o      (wr_o),
        .rd_addr_o      (rd_o),
        .cur_len_o      (len_o)
    );

    // {target, load, load value, exp wr, exp rd, exp len} from reset
    localparam logic [95:0] VEC [7] = '{
        {16'h0604, 16'h0000, 16'h0000, 16'h0001, 16'hFCFF, 16'h0602},
        {16'h0604, 16'h0001, 16'h0010, 16'h0002, 16'h0010, 16'h0604},
        {16'h0604, 16'h0000, 16'h0000, 16'h0003, 16'h000F, 16'h0604},
        {16'h0600, 16'h0000, 16'h0000, 16'h0004, 16'h000E, 16'h0602},
        {16'h0600, 16'h0001, 16'h0000, 16'h0005, 16'h0000, 16'h0600},
        {16'h0600, 16'h0000, 16'h0000, 16'h0006, 16'h05FF, 16'h0600},
        {16'h0500, 16'h0000, 16'h0000, 16'h0007, 16'h05FE, 16'h05FE}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [15:0] t, input logic l, input logic [15:0] lv);
        @(negedge clk);
        tgt = t; ld = l; ld_val = lv; stb = 1'b1;
        @(negedge clk);
        stb = 1'b0; ld = 1'b0;
    endtask

    // reference step built from the requirements, old length used throughout
    task automatic model_step(input logic [15:0] t, input logic l, input logic [15:0] lv);
        logic [16:0] inc;
        logic [15:0] old_len;
        old_len = m_len;
        inc = {1'b0, m_wr} + 17'd1;
        m_wr = (inc >= {1'b0, old_len}) ? 16'h0000 : inc[15:0];
        if (l) m_rd = lv;
        else if (m_rd == 16'h0000) m_rd = old_len - 16'd1;
        else m_rd = m_rd - 16'd1;
        if (old_len < t) m_len = old_len + 16'd2;
        else if (old_len > t) m_len = old_len - 16'd2;
    endtask

    task automatic step_and_check(input logic [15:0] t, input logic l, input logic [15:0] lv);
        pulse(t, l, lv);
        model_step(t, l, lv);
        check("R2 write", wr_o, m_wr);
        check("R4 read", rd_o, m_rd);
        check("R6 length", len_o, m_len);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 wr", wr_o, 16'h0000);
        check("R8 rd", rd_o, 16'hFD00);
        check("R8 len", len_o, 16'h0600);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R3 R5 R6 R7 R4
        for (int i = 0; i < 7; i++) begin
            pulse(VEC[i][95:80], VEC[i][64], VEC[i][63:48]);
            check("R1 vec wr", wr_o, VEC[i][47:32]);
            check("R3 vec rd", rd_o, VEC[i][31:16]);
            check("R7 vec len", len_o, VEC[i][15:0]);
        end

        // R9: no strobe, load and target asserted, nothing moves
        @(negedge clk);
        tgt = 16'h0010; ld = 1'b1; ld_val = 16'h1234;
        repeat (4) @(negedge clk);
        check("R9 wr", wr_o, 16'h0007);
        check("R9 rd", rd_o, 16'h05FE);
        check("R9 len", len_o, 16'h05FE);
        ld = 1'b0;

        m_wr = wr_o; m_rd = rd_o; m_len = len_o;

        // R2 with shrinking length: target far below the write address
        for (int i = 0; i < 40; i++) step_and_check(16'h0004, 1'b0, 16'h0);
        // R4 reload together with slew: force read to zero mid-slew
        step_and_check(16'h0004, 1'b1, 16'h0000);
        step_and_check(16'h0004, 1'b0, 16'h0000);
        // R5 load over zero-reload
        step_and_check(16'h0004, 1'b1, 16'h0000);
        step_and_check(16'h0004, 1'b1, 16'h0055);

        // mixed long run
        begin
            logic [15:0] lf;
            logic [15:0] t;
            lf = 16'hACE1;
            t = 16'h0040;
            for (int i = 0; i < 1500; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                if (i % 64 == 0) t = {5'd0, lf[10:1], 1'b0} + 16'h0010;
                step_and_check(t, (lf[4:0] == 5'd3), {6'd0, lf[9:0]});
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule